// File: doc/BRIEF.md
# GPIO and Event Interrupt Collector

The block gathers interrupt causes from two general-purpose input pins and from per-port link events, and presents them on one interrupt pin. The port events are disconnect, remote wake, attach and overvoltage. Each cause has a sticky status bit and a mask bit. Software clears a status bit by writing 1 to it. Each GPIO pin can run in edge mode or level mode. In edge mode its two causes record rising and falling transitions. In level mode the same two causes follow the pin being high or being low, and the interrupt follows the pin directly. The pin driver supports open-drain or push-pull drive and a polarity choice. A software override can force the pin to show asserted or deasserted.

Software reaches the block through a plain register port: a write strobe, an address and write data, with read data registered one cycle after the address. Event inputs are single-cycle pulses in the block's clock domain. GPIO inputs may be asynchronous and pass through a synchroniser. The pin is driven as a level plus an output enable, so a pad cell can build either drive type.

Register addresses: 0 status A, 1 status B, 2 mask A, 3 mask B, 4 GPIO mode, 5 pin setup. All other addresses read 0.

Top module: `irq_collector`

## Requirements
- R1: After reset every register reads 0, and the pin outputs have `irq_oe`=0 and `irq_level`=0.
- R2: A pulse on an event input sets its status bit. Status A bit 0 is port-0 disconnect, bit 1 is port-0 wake, bit 2 is port-1 disconnect and bit 3 is port-1 wake. Status B bit 0 is port-0 overvoltage, bit 1 is port-1 overvoltage, bit 2 is port-0 attach and bit 3 is port-1 attach. Status B bits 7:4 read 0.
- R3: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R4: An event and a write-1 to the same status bit in the same cycle leave the bit set.
- R5: In edge mode (GPIO mode bit g = 0), a rising transition sets status A bit 5 for GPIO0 or bit 7 for GPIO1. A falling transition sets bit 4 for GPIO0 or bit 6 for GPIO1. Each transition sets the bit once, so holding the pin steady after a clear does not set it again.
- R6: In level mode (GPIO mode bit g = 1), the rise mask bit asserts the interrupt while the pin is high and the fall mask bit asserts it while the pin is low. The interrupt drops when the condition ends, with no status clear.
- R7: The internal interrupt is the OR over all causes of status AND mask, with mask A and mask B bits 3:0 at the same positions as the status bits. A status bit whose mask bit is 0 does not assert the pin.
- R8: With pin setup bit 0 = 0 (open drain), an asserted interrupt gives `irq_oe`=1 and `irq_level`=0. A deasserted interrupt gives `irq_oe`=0.
- R9: With pin setup bit 0 = 1 (push-pull), `irq_oe`=1 and `irq_level` equals the asserted state XOR pin setup bit 1, where bit 1 = 1 selects active low.
- R10: When mask B bit 7 = 1, mask B bit 6 replaces the internal interrupt as the asserted state. The drive rules of R8 and R9 still apply.
- R11: The mask and setup registers read back what was written, with unused bits reading 0. The readable bits are 7, 6 and 3:0 of mask B, bits 1:0 of GPIO mode and bits 1:0 of pin setup. Read data reflects the register at `addr` one cycle after `addr` is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for write and read |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| gpio_in | input | 2 | GPIO pin levels, asynchronous |
| ev_disc | input | 2 | Per-port disconnect pulse |
| ev_wake | input | 2 | Per-port remote-wake pulse |
| ev_attach | input | 2 | Per-port attach pulse |
| ev_ovp | input | 2 | Per-port overvoltage pulse |
| irq_level | output | 1 | Level driven on the interrupt pin when enabled |
| irq_oe | output | 1 | Interrupt pin output enable |

## Verification
The assertions take for granted that event inputs are synchronous to `clk` and last exactly one cycle. They also assume GPIO pins change no faster than the synchroniser depth, so that every transition reaches the edge detector as a clean step. The stimulus drives events for a single cycle on the falling clock edge. It holds each GPIO level for several cycles before it moves the pin again or samples a result. Register writes never overlap an address change for a read.

// File: rtl/irq_collector_pkg.sv
package irq_collector_pkg;
  localparam int DATA_W    = 8;
  localparam int A_STAT_A  = 0;
  localparam int A_STAT_B  = 1;
  localparam int A_MASK_A  = 2;
  localparam int A_MASK_B  = 3;
  localparam int A_GMODE   = 4;
  localparam int A_PINCFG  = 5;
  localparam logic [DATA_W-1:0] MASK_B_USED = 8'hCF;
  localparam int OVR_EN_BIT  = 7;
  localparam int OVR_VAL_BIT = 6;
endpackage

// File: rtl/irq_gpio_front.sv
module irq_gpio_front #(
  parameter int NUM_GPIO    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_GPIO-1:0] pin_async,
  output logic [NUM_GPIO-1:0] pin_sync,
  output logic [NUM_GPIO-1:0] rise_pulse,
  output logic [NUM_GPIO-1:0] fall_pulse
);
  logic [NUM_GPIO-1:0] prev;

  for (genvar g = 0; g < NUM_GPIO; g++) begin : g_pin
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) begin
        chain   <= '0;
        prev[g] <= 1'b0;
      end else begin
        chain   <= {chain[SYNC_STAGES-2:0], pin_async[g]};
        prev[g] <= chain[SYNC_STAGES-1];
      end
    end
    assign pin_sync[g]   = chain[SYNC_STAGES-1];
    assign rise_pulse[g] = chain[SYNC_STAGES-1] & ~prev[g];
    assign fall_pulse[g] = ~chain[SYNC_STAGES-1] & prev[g];

    // R5
    single_rise_chk: assert property (@(posedge clk) disable iff (rst)
      rise_pulse[g] |=> !rise_pulse[g]);
  end
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int WIDTH = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] set_vec,
  input  logic [WIDTH-1:0] clr_vec,
  output logic [WIDTH-1:0] status
);
  always_ff @(posedge clk) begin
    if (rst) status <= '0;
    else     status <= (status & ~clr_vec) | set_vec;
  end

  // R4
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (set_vec != '0) |=> ((status & $past(set_vec)) == $past(set_vec)));

  // R3
  clear_takes_chk: assert property (@(posedge clk) disable iff (rst)
    ((clr_vec & ~set_vec) != '0) |=> ((status & $past(clr_vec & ~set_vec)) == '0));
endmodule

// File: rtl/irq_pin_drive.sv
module irq_pin_drive (
  input  logic clk,
  input  logic rst,
  input  logic irq_raw,
  input  logic ovr_en,
  input  logic ovr_val,
  input  logic push_pull,
  input  logic act_low,
  output logic pin_level,
  output logic pin_oe
);
  logic asserted;
  assign asserted = ovr_en ? ovr_val : irq_raw;

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_level <= 1'b0;
      pin_oe    <= 1'b0;
    end else if (push_pull) begin
      pin_level <= asserted ^ act_low;
      pin_oe    <= 1'b1;
    end else begin
      pin_level <= 1'b0;
      pin_oe    <= asserted;
    end
  end

  // R8
  od_never_high_chk: assert property (@(posedge clk) disable iff (rst)
    !push_pull |=> !pin_level);

  // R9
  pp_always_drives_chk: assert property (@(posedge clk) disable iff (rst)
    push_pull |=> pin_oe);

  // R10
  ovr_shows_value_chk: assert property (@(posedge clk) disable iff (rst)
    (ovr_en && push_pull && !act_low) |=> (pin_level == $past(ovr_val)));
endmodule

// File: rtl/irq_collector.sv
module irq_collector
  import irq_collector_pkg::*;
#(
  parameter int NUM_GPIO    = 2,
  parameter int NUM_PORT    = 2,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wr_data,
  output logic [DATA_W-1:0]   rd_data,
  input  logic [NUM_GPIO-1:0] gpio_in,
  input  logic [NUM_PORT-1:0] ev_disc,
  input  logic [NUM_PORT-1:0] ev_wake,
  input  logic [NUM_PORT-1:0] ev_attach,
  input  logic [NUM_PORT-1:0] ev_ovp,
  output logic                irq_level,
  output logic                irq_oe
);
  localparam int GPIO_BASE = 2 * NUM_PORT;
  localparam int B_W       = 2 * NUM_PORT;
  localparam int STAT_W    = DATA_W + B_W;

  logic [DATA_W-1:0]   mask_a, mask_b;
  logic [NUM_GPIO-1:0] gmode;
  logic [1:0]          pincfg;
  logic [NUM_GPIO-1:0] g_sync, g_rise, g_fall;
  logic [STAT_W-1:0]   set_vec, clr_vec, status, lvl_sel, lvl_hit, mask_src;
  logic                irq_raw;

  irq_gpio_front #(.NUM_GPIO(NUM_GPIO), .SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk(clk), .rst(rst), .pin_async(gpio_in),
    .pin_sync(g_sync), .rise_pulse(g_rise), .fall_pulse(g_fall));

  // Source packing: A[2p]=disc, A[2p+1]=wake, A[GPIO_BASE+2g]=fall,
  // A[GPIO_BASE+2g+1]=rise; B[p]=ovp, B[NUM_PORT+p]=attach.
  always_comb begin
    set_vec = '0;
    lvl_sel = '0;
    lvl_hit = '0;
    for (int p = 0; p < NUM_PORT; p++) begin
      set_vec[2*p]                 = ev_disc[p];
      set_vec[2*p+1]               = ev_wake[p];
      set_vec[DATA_W+p]            = ev_ovp[p];
      set_vec[DATA_W+NUM_PORT+p]   = ev_attach[p];
    end
    for (int g = 0; g < NUM_GPIO; g++) begin
      set_vec[GPIO_BASE+2*g]   = gmode[g] ? ~g_sync[g] : g_fall[g];
      set_vec[GPIO_BASE+2*g+1] = gmode[g] ?  g_sync[g] : g_rise[g];
      lvl_sel[GPIO_BASE+2*g]   = gmode[g];
      lvl_sel[GPIO_BASE+2*g+1] = gmode[g];
      lvl_hit[GPIO_BASE+2*g]   = gmode[g] & ~g_sync[g];
      lvl_hit[GPIO_BASE+2*g+1] = gmode[g] &  g_sync[g];
    end
  end

  always_comb begin
    clr_vec = '0;
    if (wr_en && addr == ADDR_W'(A_STAT_A)) clr_vec[DATA_W-1:0]      = wr_data;
    if (wr_en && addr == ADDR_W'(A_STAT_B)) clr_vec[STAT_W-1:DATA_W] = wr_data[B_W-1:0];
  end

  irq_status_bank #(.WIDTH(STAT_W)) u_bank (
    .clk(clk), .rst(rst), .set_vec(set_vec), .clr_vec(clr_vec), .status(status));

  assign mask_src = {mask_b[B_W-1:0], mask_a};
  assign irq_raw  = |(((status & ~lvl_sel) | lvl_hit) & mask_src);

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_a <= '0;
      mask_b <= '0;
      gmode  <= '0;
      pincfg <= '0;
    end else if (wr_en) begin
      case (addr)
        ADDR_W'(A_MASK_A): mask_a <= wr_data;
        ADDR_W'(A_MASK_B): mask_b <= wr_data & MASK_B_USED;
        ADDR_W'(A_GMODE):  gmode  <= wr_data[NUM_GPIO-1:0];
        ADDR_W'(A_PINCFG): pincfg <= wr_data[1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      case (addr)
        ADDR_W'(A_STAT_A): rd_data <= status[DATA_W-1:0];
        ADDR_W'(A_STAT_B): rd_data <= DATA_W'(status[STAT_W-1:DATA_W]);
        ADDR_W'(A_MASK_A): rd_data <= mask_a;
        ADDR_W'(A_MASK_B): rd_data <= mask_b;
        ADDR_W'(A_GMODE):  rd_data <= DATA_W'(gmode);
        ADDR_W'(A_PINCFG): rd_data <= DATA_W'(pincfg);
        default:           rd_data <= '0;
      endcase
    end
  end

  irq_pin_drive u_pin (
    .clk(clk), .rst(rst), .irq_raw(irq_raw),
    .ovr_en(mask_b[OVR_EN_BIT]), .ovr_val(mask_b[OVR_VAL_BIT]),
    .push_pull(pincfg[0]), .act_low(pincfg[1]),
    .pin_level(irq_level), .pin_oe(irq_oe));

  // R7
  masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!mask_b[OVR_EN_BIT] && mask_src == '0 && !pincfg[0]) |=> !irq_oe);
endmodule

// File: tb/irq_collector_tb.sv
module irq_collector_tb;
  logic       clk = 1'b0;
  logic       rst;
  logic       wr_en;
  logic [2:0] addr;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic [1:0] gpio_in;
  logic [7:0] ev;
  logic       irq_level, irq_oe;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_collector u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .gpio_in(gpio_in),
    .ev_disc(ev[1:0]), .ev_wake(ev[3:2]), .ev_attach(ev[5:4]), .ev_ovp(ev[7:6]),
    .irq_level(irq_level), .irq_oe(irq_oe));

  // {event one-hot, expected status A, expected status B}
  localparam logic [23:0] VEC [8] = '{
    {8'h01, 8'h01, 8'h00}, {8'h02, 8'h04, 8'h00},
    {8'h04, 8'h02, 8'h00}, {8'h08, 8'h08, 8'h00},
    {8'h10, 8'h00, 8'h04}, {8'h20, 8'h00, 8'h08},
    {8'h40, 8'h00, 8'h01}, {8'h80, 8'h00, 8'h02}};

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a;
    @(negedge clk); d = rd_data;
  endtask

  task automatic pulse(input logic [7:0] e);
    @(negedge clk); ev = e;
    @(negedge clk); ev = '0;
  endtask

  task automatic pin_is(input string tag, input logic oe, input logic lvl);
    idle(3);
    chk(tag, {6'b0, irq_oe, irq_level}, {6'b0, oe, lvl});
  endtask

  task automatic gpio_set(input logic [1:0] v);
    @(negedge clk); gpio_in = v;
    idle(5);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    rst = 1'b1; wr_en = 1'b0; addr = '0; wr_data = '0; gpio_in = '0; ev = '0;
    idle(4);
    rst = 1'b0;

    for (int a = 0; a < 6; a++) begin
      rd(3'(a), d); chk("R1 register reset", d, 8'h00);
    end
    chk("R1 pin reset", {6'b0, irq_oe, irq_level}, 8'h00);

    for (int i = 0; i < 8; i++) begin
      pulse(VEC[i][23:16]);
      rd(3'd0, d); chk("R2 status A map", d, VEC[i][15:8]);
      rd(3'd1, d); chk("R2 status B map", d, VEC[i][7:0]);
      wr(3'd0, 8'hFF); wr(3'd1, 8'hFF);
      rd(3'd0, d); chk("R3 clear A", d, 8'h00);
      rd(3'd1, d); chk("R3 clear B", d, 8'h00);
    end

    pulse(8'h01);
    wr(3'd0, 8'hFE); rd(3'd0, d); chk("R3 write 0 keeps", d, 8'h01);
    wr(3'd0, 8'h01); rd(3'd0, d); chk("R3 write 1 clears", d, 8'h00);

    @(negedge clk); ev = 8'h01; wr_en = 1'b1; addr = 3'd0; wr_data = 8'h01;
    @(negedge clk); ev = '0; wr_en = 1'b0;
    rd(3'd0, d); chk("R4 event beats clear", d, 8'h01);
    wr(3'd0, 8'hFF);

    gpio_set(2'b01); rd(3'd0, d); chk("R5 gpio0 rise", d, 8'h20);
    wr(3'd0, 8'hFF); idle(4); rd(3'd0, d); chk("R5 hold no retrigger", d, 8'h00);
    gpio_set(2'b00); rd(3'd0, d); chk("R5 gpio0 fall", d, 8'h10);
    wr(3'd0, 8'hFF);
    gpio_set(2'b10); rd(3'd0, d); chk("R5 gpio1 rise", d, 8'h80);
    gpio_set(2'b00); rd(3'd0, d); chk("R5 gpio1 fall", d, 8'hC0);
    wr(3'd0, 8'hFF);

    pulse(8'h01);
    pin_is("R7 masked source quiet", 1'b0, 1'b0);
    wr(3'd2, 8'h01);
    pin_is("R8 open drain asserted", 1'b1, 1'b0);
    wr(3'd0, 8'h01);
    pin_is("R8 open drain released", 1'b0, 1'b0);

    wr(3'd5, 8'h01);
    pin_is("R9 push-pull idle high-active", 1'b1, 1'b0);
    pulse(8'h01);
    pin_is("R9 push-pull asserted high", 1'b1, 1'b1);
    wr(3'd5, 8'h03);
    pin_is("R9 push-pull asserted low", 1'b1, 1'b0);
    wr(3'd0, 8'h01);
    pin_is("R9 push-pull idle active-low", 1'b1, 1'b1);

    wr(3'd5, 8'h00);
    wr(3'd3, 8'hC0);
    pin_is("R10 override asserts open drain", 1'b1, 1'b0);
    pulse(8'h01);
    wr(3'd3, 8'h80);
    pin_is("R10 override masks pending", 1'b0, 1'b0);
    wr(3'd5, 8'h01); wr(3'd3, 8'hC0);
    pin_is("R10 override push-pull", 1'b1, 1'b1);
    wr(3'd3, 8'h00); wr(3'd5, 8'h00); wr(3'd2, 8'h00); wr(3'd0, 8'hFF);

    wr(3'd4, 8'h01); wr(3'd2, 8'h20);
    pin_is("R6 level low, rise mask", 1'b0, 1'b0);
    gpio_set(2'b01);
    chk("R6 level high asserts", {6'b0, irq_oe, irq_level}, 8'h02);
    gpio_set(2'b00);
    chk("R6 level low releases", {6'b0, irq_oe, irq_level}, 8'h00);
    rd(3'd0, d); chk("R6 level status seen", d, 8'h30);
    wr(3'd2, 8'h10);
    pin_is("R6 fall mask asserts on low", 1'b1, 1'b0);
    wr(3'd2, 8'h00); wr(3'd4, 8'h00); wr(3'd0, 8'hFF);

    wr(3'd2, 8'hA5); rd(3'd2, d); chk("R11 mask A readback", d, 8'hA5);
    wr(3'd3, 8'h3F); rd(3'd3, d); chk("R11 mask B unused zero", d, 8'h0F);
    wr(3'd4, 8'hFF); rd(3'd4, d); chk("R11 gpio mode width", d, 8'h03);
    wr(3'd5, 8'hFE); rd(3'd5, d); chk("R11 pin setup width", d, 8'h02);
    rd(3'd7, d); chk("R11 unmapped reads zero", d, 8'h00);

    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule